// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character at a time into an asynchronous frame on a single serial line. A frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and then one, one and a half or two high stop bits. Six format inputs set the frame layout: word length, stop-bit selection, parity enable, even/odd selection, stick parity and a break-force control. The line idles high.

A character is handed over through a valid/ready handshake. The block takes it only while no frame is in progress. Timing comes from a single-cycle enable, `tick_16x`, that pulses at 16 times the bit rate. Each full bit lasts 16 of these pulses. The block reports an active frame on `tx_busy`. The format is captured along with the character, so a host may change the format inputs for the next character while the current frame is still on the line. Break acts on the output pin alone. While break is set the line is held low, but the frame underneath keeps advancing, so a frame in progress finishes on time.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_busy` is 0 and `in_ready` is 1. While idle and without break, `tx_line` stays 1.
- R2: `in_ready` is 1 exactly when `tx_busy` is 0. A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `tx_busy` is 1 and the start bit (0) is on `tx_line` for 16 ticks.
- R3: `fmt_len` sets the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The low bits of `in_data` are sent least significant bit first, each for 16 ticks. Data bits above the word length are ignored.
- R4: With `fmt_two_stop` = 0, one stop bit (1, 16 ticks) ends the frame for every word length.
- R5: With `fmt_two_stop` = 1, a 5-bit word gets one and a half stop bits (24 ticks). 6-, 7- and 8-bit words get two stop bits (32 ticks).
- R6: With `fmt_par_en` = 1, one parity bit of 16 ticks follows the last data bit and comes before the stop bits. With `fmt_par_en` = 0, no parity bit is sent.
- R7: With parity on and stick off, `fmt_par_even` = 1 makes the count of ones over the data and parity bits even. `fmt_par_even` = 0 makes that count odd.
- R8: With parity on and `fmt_par_stick` = 1, the parity bit is 0 when `fmt_par_even` = 1 and 1 when `fmt_par_even` = 0, whatever the data.
- R9: In the cycle after `fmt_break` is sampled at 1, `tx_line` is 0. Break changes neither the frame timing nor `tx_busy`. When break drops, the line shows whichever bit the frame has reached.
- R10: The format inputs are sampled when the character is accepted. Changing them during a frame has no effect on that frame.
- R11: The frame advances only on clock edges where `tick_16x` is 1. Without ticks, `tx_line` and `tx_busy` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_16x | input | 1 | Baud enable at 16 times the bit rate |
| fmt_len | input | 2 | Word length code: 0..3 gives 5..8 bits |
| fmt_two_stop | input | 1 | Stop select: 0 gives 1 stop bit, 1 gives 1.5 (5-bit word) or 2 stop bits |
| fmt_par_en | input | 1 | Parity bit enable |
| fmt_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| fmt_par_stick | input | 1 | Forces the parity bit to the inverse of `fmt_par_even` |
| fmt_break | input | 1 | Holds the serial line low |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character, LSB sent first |
| in_ready | output | 1 | Block can take a character |
| tx_line | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | Frame in progress |

## Verification
Break and frame shifting can act in the same cycle. So can a format change and an ongoing frame. The bench raises `fmt_break` in the middle of a frame and later drops it, so the pin override and the underlying bit sequence act in the same cycles. A behavioural model that ignores break for timing judges whether the line comes back on the correct bit at the correct tick. The bench also changes every format input in the cycle after acceptance, and it holds `in_valid` high across a frame boundary. Both are checked every clock against the model, which captured the format at acceptance.

// File: rtl/sft_pkg.sv
package sft_pkg;
  parameter int unsigned SFT_MAX_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } sft_phase_e;

  typedef struct packed {
    logic [1:0] len;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } sft_fmt_t;
endpackage

// File: rtl/sft_rst_sync.sv
module sft_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/sft_parity.sv
module sft_parity #(
  parameter int W = sft_pkg::SFT_MAX_W
) (
  input  logic [W-1:0]     data,
  input  sft_pkg::sft_fmt_t fmt,
  output logic             par_bit
);
  localparam int MIN_W = W - 3;

  logic [W-1:0] masked;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign masked[i] = data[i] & (i < MIN_W + int'(fmt.len));
  end

  logic ones_odd;
  assign ones_odd = ^masked;

  always_comb begin
    if (fmt.par_stick) par_bit = ~fmt.par_even;
    else if (fmt.par_even) par_bit = ones_odd;
    else par_bit = ~ones_odd;
  end
endmodule

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_q_n,
  input  logic tick,
  input  logic restart,
  input  logic half,
  output logic seg_end
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] FULL_LIM = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_LIM = CW'(OVS / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign seg_end = tick && (cnt_q == (half ? HALF_LIM : FULL_LIM));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)      cnt_d = '0;
    else if (seg_end) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sft_tx_fsm.sv
module sft_tx_fsm
  import sft_pkg::*;
#(
  parameter int W   = SFT_MAX_W,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic         tick,
  input  logic         brk,
  input  logic         accept,
  input  logic [W-1:0] data_in,
  input  sft_fmt_t     fmt_in,
  input  logic         par_in,
  output logic         line,
  output logic         busy
);
  localparam int MIN_W = W - 3;
  localparam int BCW   = $clog2(W);

  sft_phase_e     phase_q, phase_d;
  logic [W-1:0]   shreg_q, shreg_d;
  logic [BCW-1:0] bits_q, bits_d;
  logic [2:0]     halves_q, halves_d;
  sft_fmt_t       fmt_q, fmt_d;
  logic           par_q, par_d;
  logic           line_q, line_d;
  logic           seg_end;
  logic           level;

  sft_bit_timer #(.OVS(OVS)) u_timer (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .tick    (tick),
    .restart (accept),
    .half    (phase_q == PH_STOP),
    .seg_end (seg_end)
  );

  always_comb begin
    phase_d  = phase_q;
    shreg_d  = shreg_q;
    bits_d   = bits_q;
    halves_d = halves_q;
    fmt_d    = fmt_q;
    par_d    = par_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d = PH_START;
          shreg_d = data_in;
          fmt_d   = fmt_in;
          par_d   = par_in;
          bits_d  = BCW'(MIN_W - 1) + BCW'(fmt_in.len);
        end
      end
      PH_START: begin
        if (seg_end) phase_d = PH_DATA;
      end
      PH_DATA: begin
        if (seg_end) begin
          if (bits_q == '0) begin
            if (fmt_q.par_en) phase_d = PH_PAR;
            else              phase_d = PH_STOP;
          end else begin
            shreg_d = shreg_q >> 1;
            bits_d  = bits_q - 1'b1;
          end
        end
      end
      PH_PAR: begin
        if (seg_end) phase_d = PH_STOP;
      end
      PH_STOP: begin
        if (seg_end) begin
          if (halves_q == 3'd1) phase_d = PH_IDLE;
          else                  halves_d = halves_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    // stop length in half bits, loaded whenever the stop phase is entered
    if (phase_q != PH_STOP && phase_d == PH_STOP) begin
      if (!fmt_q.two_stop)        halves_d = 3'd2;
      else if (fmt_q.len == 2'd0) halves_d = 3'd3;
      else                        halves_d = 3'd4;
    end
  end

  always_comb begin
    unique case (phase_d)
      PH_START: level = 1'b0;
      PH_DATA:  level = shreg_d[0];
      PH_PAR:   level = par_d;
      default:  level = 1'b1;
    endcase
    line_d = brk ? 1'b0 : level;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      phase_q  <= PH_IDLE;
      shreg_q  <= '0;
      bits_q   <= '0;
      halves_q <= '0;
      fmt_q    <= '0;
      par_q    <= 1'b0;
      line_q   <= 1'b1;
    end else begin
      phase_q  <= phase_d;
      shreg_q  <= shreg_d;
      bits_q   <= bits_d;
      halves_q <= halves_d;
      fmt_q    <= fmt_d;
      par_q    <= par_d;
      line_q   <= line_d;
    end
  end

  assign line = line_q;
  assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int W          = SFT_MAX_W,
  parameter int OVS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_16x,
  input  logic [1:0]   fmt_len,
  input  logic         fmt_two_stop,
  input  logic         fmt_par_en,
  input  logic         fmt_par_even,
  input  logic         fmt_par_stick,
  input  logic         fmt_break,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         tx_line,
  output logic         tx_busy
);
  logic     rst_q_n;
  logic     accept;
  logic     par_bit;
  sft_fmt_t fmt_now;

  sft_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign fmt_now = '{len: fmt_len, two_stop: fmt_two_stop, par_en: fmt_par_en,
                     par_even: fmt_par_even, par_stick: fmt_par_stick};

  sft_parity #(.W(W)) u_par (
    .data    (in_data),
    .fmt     (fmt_now),
    .par_bit (par_bit)
  );

  assign in_ready = ~tx_busy;
  assign accept   = in_valid & in_ready;

  sft_tx_fsm #(.W(W), .OVS(OVS)) u_fsm (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .tick    (tick_16x),
    .brk     (fmt_break),
    .accept  (accept),
    .data_in (in_data),
    .fmt_in  (fmt_now),
    .par_in  (par_bit),
    .line    (tx_line),
    .busy    (tx_busy)
  );
endmodule

// File: rtl/sft_checker.sv
module sft_checker (
  input logic clk,
  input logic rst_q_n,
  input logic tick_16x,
  input logic fmt_break,
  input logic in_valid,
  input logic in_ready,
  input logic tx_line,
  input logic tx_busy
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) armed_q <= 1'b0;
    else          armed_q <= 1'b1;
  end

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && in_ready |=> tx_busy && !tx_line);

  // R9
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    armed_q && fmt_break |=> !tx_line);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    armed_q && !tx_busy && !fmt_break |=> tx_busy || tx_line);

  // R11
  no_tick_busy_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    tx_busy && !tick_16x |=> tx_busy);

  // R11
  no_tick_line_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    armed_q && tx_busy && !tick_16x && $stable(fmt_break) |=> $stable(tx_line));
endmodule

bind serial_frame_tx sft_checker u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .tick_16x  (tick_16x),
  .fmt_break (fmt_break),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .tx_line   (tx_line),
  .tx_busy   (tx_busy)
);

// File: tb/serial_frame_tx_tb.sv
`timescale 1ns/1ps
module serial_frame_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_16x;
  logic [1:0] fmt_len;
  logic       fmt_two_stop, fmt_par_en, fmt_par_even, fmt_par_stick, fmt_break;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready, tx_line, tx_busy;

  always #2.5 clk = ~clk;

  serial_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .fmt_len(fmt_len),
    .fmt_two_stop(fmt_two_stop), .fmt_par_en(fmt_par_en), .fmt_par_even(fmt_par_even),
    .fmt_par_stick(fmt_par_stick), .fmt_break(fmt_break), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .tx_line(tx_line), .tx_busy(tx_busy)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    tick_en = 1'b1;
  string cur_req = "R1";

  // behavioural reference: queue of (level, duration in ticks)
  int q_lvl[$];
  int q_dur[$];
  bit m_busy = 1'b0;
  int m_cnt = 0;
  bit exp_line = 1'b1;

  task automatic build_frame();
    int wl = 5 + int'(fmt_len);
    int ones = 0;
    int p;
    q_lvl.push_back(0); q_dur.push_back(16);
    for (int i = 0; i < wl; i++) begin
      q_lvl.push_back(int'(in_data[i])); q_dur.push_back(16);
      ones += int'(in_data[i]);
    end
    if (fmt_par_en) begin
      if (fmt_par_stick) p = fmt_par_even ? 0 : 1;
      else if (fmt_par_even) p = ones % 2;
      else p = 1 - (ones % 2);
      q_lvl.push_back(p); q_dur.push_back(16);
    end
    q_lvl.push_back(1);
    if (!fmt_two_stop) q_dur.push_back(16);
    else if (wl == 5)  q_dur.push_back(24);
    else               q_dur.push_back(32);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_cnt = 0; q_lvl.delete(); q_dur.delete(); exp_line = 1'b1;
    end else begin
      if (!m_busy) begin
        if (in_valid) begin
          build_frame();
          m_busy = 1'b1; m_cnt = 0;
        end
      end else if (tick_16x) begin
        m_cnt++;
        if (m_cnt == q_dur[0]) begin
          void'(q_lvl.pop_front()); void'(q_dur.pop_front());
          m_cnt = 0;
          if (q_lvl.size() == 0) m_busy = 1'b0;
        end
      end
      exp_line = fmt_break ? 1'b0 : (m_busy ? q_lvl[0][0] : 1'b1);
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // per-cycle comparison and tick generation
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      n_chk++;
      if (tx_line !== exp_line || tx_busy !== m_busy || in_ready !== !m_busy) begin
        n_fail++;
        $display("FAIL %s cycle %0d: line/busy/ready = %b%b%b expected %b%b%b",
                 cur_req, cyc, tx_line, tx_busy, in_ready, exp_line, m_busy, !m_busy);
      end
    end
    tick_16x = tick_en && (cyc % 3 != 1);
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      report();
    end
  end

  task automatic set_fmt(input logic [1:0] len, input logic two, input logic pe,
                         input logic ev, input logic st);
    fmt_len = len; fmt_two_stop = two; fmt_par_en = pe; fmt_par_even = ev; fmt_par_stick = st;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; tick_16x = 1'b0; in_valid = 1'b0; in_data = '0; fmt_break = 1'b0;
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    n_chk++;
    if (tx_line !== 1'b1 || tx_busy !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset: line/busy/ready = %b%b%b expected 101", tx_line, tx_busy, in_ready);
    end

    cur_req = "R3"; set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b0); send(8'hA5); wait_idle();
    cur_req = "R3"; set_fmt(2'd0, 1'b0, 1'b0, 1'b0, 1'b0); send(8'hEA); wait_idle();
    cur_req = "R4"; set_fmt(2'd2, 1'b0, 1'b0, 1'b0, 1'b0); send(8'h3C); wait_idle();
    cur_req = "R5"; set_fmt(2'd0, 1'b1, 1'b0, 1'b0, 1'b0); send(8'h13); wait_idle();
    cur_req = "R5"; set_fmt(2'd1, 1'b1, 1'b0, 1'b0, 1'b0); send(8'h2D); wait_idle();
    cur_req = "R6"; set_fmt(2'd3, 1'b0, 1'b1, 1'b1, 1'b0); send(8'h0F); wait_idle();
    cur_req = "R7"; set_fmt(2'd3, 1'b0, 1'b1, 1'b1, 1'b0); send(8'h07); wait_idle();
    cur_req = "R7"; set_fmt(2'd1, 1'b1, 1'b1, 1'b0, 1'b0); send(8'hED); wait_idle();
    cur_req = "R8"; set_fmt(2'd3, 1'b0, 1'b1, 1'b1, 1'b1); send(8'h01); wait_idle();
    cur_req = "R8"; set_fmt(2'd2, 1'b0, 1'b1, 1'b0, 1'b1); send(8'h03); wait_idle();

    // R9: break raised mid-frame, framing continues underneath
    cur_req = "R9"; set_fmt(2'd3, 1'b1, 1'b1, 1'b0, 1'b0); send(8'h5A);
    repeat (40) @(negedge clk);
    fmt_break = 1'b1;
    repeat (100) @(negedge clk);
    fmt_break = 1'b0;
    wait_idle();
    fmt_break = 1'b1; repeat (20) @(negedge clk); fmt_break = 1'b0;
    repeat (5) @(negedge clk);

    // R10: format inputs change right after acceptance
    cur_req = "R10"; set_fmt(2'd0, 1'b1, 1'b1, 1'b1, 1'b0); send(8'h16);
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_idle();

    // R11: ticks withheld mid-frame
    cur_req = "R11"; set_fmt(2'd2, 1'b0, 1'b1, 1'b0, 1'b0); send(8'h44);
    repeat (50) @(negedge clk);
    tick_en = 1'b0;
    repeat (200) @(negedge clk);
    tick_en = 1'b1;
    wait_idle();

    // R2: valid held across a frame boundary gives back-to-back frames
    cur_req = "R2"; set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hC3;
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    report();
  end
endmodule